// File: doc/BRIEF.md
# Global-History Two-Bit Branch Direction Predictor

This block predicts branch direction for an instruction fetch stage. It holds a table of 2-bit saturating counters. Each row of the table is picked by a slice of the program counter, and the current global history picks one counter within that row. A lookup takes a fetch PC and returns a taken or not-taken guess, together with the counter it was read from, in the same cycle and without a register on the path.

The execute stage sends back resolved branches on an update port. Each update carries the PC and the actual outcome. The update trains the counter that the current history selects in that PC's row, and it shifts the outcome into the history register. History changes only on these resolved updates. Nothing is updated speculatively at fetch, so the block needs no recovery.

Every counter starts in the weakly not-taken state. No cycle-by-cycle sweep is needed for this: a per-row valid bitmap makes rows that have never been written read back as that state.

Top module: `bp_gh_predictor`

## Requirements
- R1: While reset is asserted and after it is released, every lookup reads counter value 01 and predicts not taken, and the history output reads 00.
- R2: The row index is PC bits [IDX_W+1:2], with IDX_W = 12 by default. PCs that differ only in bits [1:0], or only above bit IDX_W+1, share a row. A PC with a different index leaves the row of another PC untouched.
- R3: `pred_taken_o` is 1 exactly when the selected counter value is 2 or 3.
- R4: An update with outcome taken raises the selected counter by one, up to a ceiling of 3.
- R5: An update with outcome not taken lowers the selected counter by one, down to a floor of 0.
- R6: Each valid update shifts the history left by one, and the outcome enters at bit 0 (1 = taken). Bit 0 is therefore the newest outcome.
- R7: The history value h (0..3) selects counter h of the row. Both the lookup and the training of an update use the history held before that cycle's shift. Counters of the same row under different history values are independent.
- R8: When an update and a lookup address the same counter in one cycle, the lookup returns the value from before the update.
- R9: When `upd_valid_i` is 0, neither the counters nor the history change, whatever `upd_pc_i` and `upd_taken_i` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lookup_pc_i | input | PC_W | Fetch PC to predict |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_ctr_o | output | 2 | Counter value behind the prediction |
| upd_valid_i | input | 1 | Resolved branch present this cycle |
| upd_pc_i | input | PC_W | PC of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome, 1 = taken |
| hist_o | output | HIST_W | Current global history |

## Verification
The bench drives one row into both saturation limits and holds it there. A counter without saturation would wrap from 3 to 0 and flip a strongly taken prediction. It uses history changes to show that each history value reaches its own counter in the same row. A design that ignored the history, or that used the post-shift history, would read back a counter trained under a different pattern. It also looks up a row while that row is being written, and it sends invalid updates with live-looking data; a write-through design or one that gated badly would show the new value or drift. PCs that alias in the low two bits and in the bits above the index show whether the index slice sits in the right place, and a reset in the middle of a run shows whether trained rows fall back to weakly not-taken.

// File: rtl/bp_gh_pkg.sv
package bp_gh_pkg;
  localparam int unsigned CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_INIT = 2'b01;  // weakly not-taken

  function automatic ctr_t ctr_next(input ctr_t c, input logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'd1;
    else       return (c == 2'b00) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/bp_gh_hist.sv
module bp_gh_hist #(
  parameter int unsigned HIST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  // R6: newest outcome enters at bit 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= {hist_q[HIST_W-2:0], bit_i};
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/bp_gh_table.sv
module bp_gh_table #(
  parameter int unsigned IDX_W  = 12,
  parameter int unsigned WORD_W = 8,
  parameter logic [WORD_W-1:0] INIT_WORD = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  ra_idx_i,
  output logic [WORD_W-1:0] ra_word_o,
  input  logic [IDX_W-1:0]  rb_idx_i,
  output logic [WORD_W-1:0] rb_word_o,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  w_idx_i,
  input  logic [WORD_W-1:0] w_word_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;

  // rows never written read as INIT_WORD (R1), so reset is one vector clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   vld_q <= '0;
    else if (we_i) vld_q[w_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[w_idx_i] <= w_word_i;
  end

  // read-before-write: reads see state before this edge (R8)
  assign ra_word_o = vld_q[ra_idx_i] ? mem_q[ra_idx_i] : INIT_WORD;
  assign rb_word_o = vld_q[rb_idx_i] ? mem_q[rb_idx_i] : INIT_WORD;
endmodule

// File: rtl/bp_gh_train.sv
module bp_gh_train #(
  parameter int unsigned HIST_W = 2
) (
  input  logic [HIST_W-1:0]                          sel_i,
  input  logic                                       taken_i,
  input  logic [(1<<HIST_W)*bp_gh_pkg::CTR_W-1:0]   old_word_i,
  output logic [(1<<HIST_W)*bp_gh_pkg::CTR_W-1:0]   new_word_o
);
  import bp_gh_pkg::*;
  localparam int unsigned SETS = 1 << HIST_W;

  // R4/R5: only the lane picked by history moves; others pass through (R7)
  for (genvar g = 0; g < SETS; g++) begin : g_lane
    ctr_t old_c;
    assign old_c = old_word_i[g*CTR_W +: CTR_W];
    assign new_word_o[g*CTR_W +: CTR_W] =
      (sel_i == HIST_W'(g)) ? ctr_next(old_c, taken_i) : old_c;
  end
endmodule

// File: rtl/bp_gh_predictor.sv
module bp_gh_predictor #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned IDX_W  = 12,
  parameter int unsigned HIST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   lookup_pc_i,
  output logic              pred_taken_o,
  output logic [1:0]        pred_ctr_o,
  input  logic              upd_valid_i,
  input  logic [PC_W-1:0]   upd_pc_i,
  input  logic              upd_taken_i,
  output logic [HIST_W-1:0] hist_o
);
  import bp_gh_pkg::*;
  localparam int unsigned SETS   = 1 << HIST_W;
  localparam int unsigned WORD_W = SETS * CTR_W;
  localparam logic [WORD_W-1:0] INIT_WORD = {SETS{CTR_INIT}};

  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [WORD_W-1:0] lk_word, up_word, up_word_new;
  logic [HIST_W-1:0] hist;
  ctr_t              lk_ctr;

  // R2: drop the two alignment bits
  assign lk_idx = lookup_pc_i[IDX_W+1:2];
  assign up_idx = upd_pc_i[IDX_W+1:2];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{lookup_pc_i[PC_W-1:IDX_W+2], lookup_pc_i[1:0],
                            upd_pc_i[PC_W-1:IDX_W+2], upd_pc_i[1:0]};

  bp_gh_hist #(.HIST_W(HIST_W)) u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (upd_valid_i),
    .bit_i   (upd_taken_i),
    .hist_o  (hist)
  );

  bp_gh_table #(
    .IDX_W     (IDX_W),
    .WORD_W    (WORD_W),
    .INIT_WORD (INIT_WORD)
  ) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ra_idx_i  (lk_idx),
    .ra_word_o (lk_word),
    .rb_idx_i  (up_idx),
    .rb_word_o (up_word),
    .we_i      (upd_valid_i),
    .w_idx_i   (up_idx),
    .w_word_i  (up_word_new)
  );

  // R7: training uses the pre-shift history
  bp_gh_train #(.HIST_W(HIST_W)) u_train (
    .sel_i      (hist),
    .taken_i    (upd_taken_i),
    .old_word_i (up_word),
    .new_word_o (up_word_new)
  );

  assign lk_ctr       = lk_word[hist*CTR_W +: CTR_W];
  assign pred_ctr_o   = lk_ctr;
  assign pred_taken_o = lk_ctr[CTR_W-1];  // R3
  assign hist_o       = hist;
endmodule

// File: rtl/bp_gh_predictor_chk.sv
module bp_gh_predictor_chk #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned IDX_W  = 12,
  parameter int unsigned HIST_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PC_W-1:0]   lookup_pc_i,
  input logic [1:0]        pred_ctr_o,
  input logic              upd_valid_i,
  input logic [PC_W-1:0]   upd_pc_i,
  input logic              upd_taken_i,
  input logic [HIST_W-1:0] hist_o
);
  localparam logic [HIST_W-1:0] ONES = {HIST_W{1'b1}};

  logic [IDX_W-1:0] lk_idx, up_idx;
  assign lk_idx = lookup_pc_i[IDX_W+1:2];
  assign up_idx = upd_pc_i[IDX_W+1:2];

  logic unused_chk_bits;
  assign unused_chk_bits = ^{lookup_pc_i[PC_W-1:IDX_W+2], lookup_pc_i[1:0],
                             upd_pc_i[PC_W-1:IDX_W+2], upd_pc_i[1:0]};

  a_r6_hist_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> hist_o == {$past(hist_o[HIST_W-2:0]), $past(upd_taken_i)});

  a_r9_hist_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(hist_o));

  // all-ones history stays all-ones after a taken shift, so the same counter is seen next cycle
  a_r4_sat_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i && hist_o == ONES && lk_idx == up_idx) |=>
    (!$stable(lk_idx) ||
     pred_ctr_o == (($past(pred_ctr_o) == 2'd3) ? 2'd3 : $past(pred_ctr_o) + 2'd1)));

  a_r5_sat_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i && hist_o == '0 && lk_idx == up_idx) |=>
    (!$stable(lk_idx) ||
     pred_ctr_o == (($past(pred_ctr_o) == 2'd0) ? 2'd0 : $past(pred_ctr_o) - 2'd1)));
endmodule

bind bp_gh_predictor bp_gh_predictor_chk #(
  .PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)
) u_chk (.*);

// File: tb/bp_gh_predictor_bench.sv
module bp_gh_predictor_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] lookup_pc = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic        pred_taken;
  logic [1:0]  pred_ctr;
  logic [1:0]  hist;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bp_gh_predictor u_bp_gh_predictor (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .lookup_pc_i  (lookup_pc),
    .pred_taken_o (pred_taken),
    .pred_ctr_o   (pred_ctr),
    .upd_valid_i  (upd_valid),
    .upd_pc_i     (upd_pc),
    .upd_taken_i  (upd_taken),
    .hist_o       (hist)
  );

  typedef struct packed {
    logic [31:0] lk;
    logic        uv;
    logic [31:0] up;
    logic        ut;
    logic [1:0]  ctr;   // expected counter before the edge
    logic [1:0]  hst;   // expected history before the edge
    logic [7:0]  req;
  } vec_t;

  localparam logic [31:0] PA = 32'h0000_0100;  // row 0x040
  localparam logic [31:0] PB = 32'h0000_0104;  // row 0x041

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{PA, 1'b1, PA, 1'b1, 2'b01, 2'b00, 8'd8},  // R8 old value seen while writing
    '{PA, 1'b1, PA, 1'b1, 2'b01, 2'b01, 8'd6},  // R6 history 01
    '{PA, 1'b1, PA, 1'b1, 2'b01, 2'b11, 8'd7},  // R7 fresh lane under 11
    '{PA, 1'b1, PA, 1'b1, 2'b10, 2'b11, 8'd4},  // R4
    '{PA, 1'b1, PA, 1'b1, 2'b11, 2'b11, 8'd4},  // R4 at ceiling
    '{PA, 1'b0, PA, 1'b1, 2'b11, 2'b11, 8'd4},  // R4 stayed at 3 ; R9 invalid taken
    '{PA, 1'b0, PA, 1'b0, 2'b11, 2'b11, 8'd9},  // R9 invalid not-taken
    '{PA, 1'b1, PA, 1'b0, 2'b11, 2'b11, 8'd5},  // R5
    '{PA, 1'b1, PA, 1'b0, 2'b01, 2'b10, 8'd6},  // R6 history 10
    '{PA, 1'b1, PA, 1'b0, 2'b10, 2'b00, 8'd7},  // R7 lane 00 kept its 10
    '{PA, 1'b1, PA, 1'b0, 2'b01, 2'b00, 8'd5},  // R5
    '{PA, 1'b1, PA, 1'b0, 2'b00, 2'b00, 8'd5},  // R5 at floor
    '{PA, 1'b0, PB, 1'b1, 2'b00, 2'b00, 8'd9},  // R9 invalid update to PB
    '{PB, 1'b0, PA, 1'b0, 2'b01, 2'b00, 8'd2},  // R2 neighbour row untouched
    '{32'h0000_0101, 1'b0, PA, 1'b0, 2'b00, 2'b00, 8'd2},  // R2 low bits alias
    '{32'h0000_4100, 1'b0, PA, 1'b0, 2'b00, 2'b00, 8'd2},  // R2 high bits alias
    '{PA, 1'b1, PB, 1'b1, 2'b00, 2'b00, 8'd7},  // R7 train PB lane 00
    '{PB, 1'b0, PA, 1'b0, 2'b01, 2'b01, 8'd7},  // R7 PB lane 01 independent
    '{PA, 1'b0, PA, 1'b0, 2'b10, 2'b01, 8'd7}   // R7 PA lane 01 from step 2
  };

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] lk, input logic uv,
                       input logic [31:0] up, input logic ut);
    @(negedge clk);
    lookup_pc = lk; upd_valid = uv; upd_pc = up; upd_taken = ut;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 while in reset
    drive(PA, 1'b1, PA, 1'b1);
    @(negedge clk); #1;
    chk("R1", int'(pred_ctr), 1, "ctr in reset");
    chk("R1", int'(hist), 0, "hist in reset");
    chk("R1", int'(pred_taken), 0, "pred in reset");
    @(negedge clk);
    upd_valid = 1'b0;
    rst_ni = 1'b1;
    #1;
    chk("R1", int'(pred_ctr), 1, "ctr after release");
    chk("R1", int'(hist), 0, "hist after release");

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].lk, VECS[i].uv, VECS[i].up, VECS[i].ut);
      chk($sformatf("R%0d", VECS[i].req), int'(pred_ctr), int'(VECS[i].ctr),
          $sformatf("ctr step %0d", i));
      chk($sformatf("R%0d", VECS[i].req), int'(hist), int'(VECS[i].hst),
          $sformatf("hist step %0d", i));
      chk("R3", int'(pred_taken), int'(VECS[i].ctr[1]), $sformatf("pred step %0d", i));
    end

    // R1 mid-run reset clears trained rows and history
    drive(PA, 1'b0, PA, 1'b0);
    rst_ni = 1'b0;
    #1;
    chk("R1", int'(pred_ctr), 1, "ctr PA in mid reset");
    chk("R1", int'(hist), 0, "hist in mid reset");
    @(negedge clk);
    rst_ni = 1'b1;
    lookup_pc = PB;
    #1;
    chk("R1", int'(pred_ctr), 1, "ctr PB after mid reset");
    chk("R1", int'(pred_taken), 0, "pred PB after mid reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule